// File: doc/BRIEF.md
# Hybrid Static/Dynamic Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It works in the decode stage, where decoded operations wait in the queue before register renaming. For each lookup the front end gives the branch address and its target address. The block answers in the same cycle with a direction and a flag that says which path produced it. The branch address selects one row of a small direct-mapped, tagged table. When the row is valid and its tag matches, the prediction is dynamic. The row's 4-bit record of that branch's recent outcomes then picks a 2-bit saturating counter from a shared pattern table, and the counter's upper bit gives the direction. When the row does not match, a fixed rule is used instead: a branch whose target lies below its own address is predicted taken, and every other branch is predicted not taken.

Resolved branches come back through a separate update port. When the update hits the table, the branch trains the counter its history selects and shifts its outcome into that history. When the update misses, it claims the row, writing the tag and filling the history with the outcome.

Top module: `bp_hybrid_predictor`

## Requirements
- R1: After reset every row is invalid, so every lookup uses the fixed rule and predHit is 0. Every pattern counter resets to 1 (weakly not taken).
- R2: On a lookup that misses, predTaken is 1 exactly when lookupTarget is lower than lookupPc as unsigned numbers. A target equal to or above the branch address gives 0.
- R3: The row is chosen by the low IDX_W bits of the address. A lookup hits only when that row is valid and the stored tag equals the remaining upper address bits. Two addresses that share a row but differ in the upper bits do not hit each other's row.
- R4: On a lookup that hits, predHit is 1 and predTaken equals the upper bit of the pattern counter indexed by the row's 4-bit history.
- R5: An update that hits increments the counter indexed by the row's history when the outcome is taken and decrements it when not taken. The counter saturates at 3 and at 0.
- R6: An update that hits replaces the row's history h with {h[2:0], outcome}, so the newest outcome sits in bit 0.
- R7: An update that misses sets the row valid, writes the upper address bits as its tag, and fills all four history bits with the outcome. It leaves every pattern counter unchanged, and it replaces any other branch that held the row.
- R8: When a lookup and an update touch the same row in the same cycle, the lookup sees the state from before the update. The update takes effect from the next cycle on.
- R9: While updValid is 0, the tables do not change, whatever is on updPc and updTaken.
- R10: While lookupValid is 0, predTaken and predHit are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A branch is presented for prediction |
| lookupPc | input | ADDR_W | Address of the branch being predicted |
| lookupTarget | input | ADDR_W | Target address of that branch |
| updValid | input | 1 | A resolved branch is presented for training |
| updPc | input | ADDR_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved direction, 1 = taken |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predHit | output | 1 | 1 when the table produced the prediction, 0 when the fixed rule did |

## Verification
The bench builds the block with ADDR_W = 8 and the default IDX_W = 4, which leaves a 4-bit tag. With these values every branch address can be swept for the fixed rule, with targets just below, equal to and just above it. The random phase confines the upper bits to two tag values, so rows are hit, aliased and replaced often. This drives every history pattern and every counter through both saturation limits, including cycles where the lookup and the update land on the same row.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Strobes from control to datapath for one update cycle.
  typedef struct packed {
    logic alloc;    // claim the row for a missing branch
    logic train;    // train counter and shift history of a hitting branch
    logic outcome;  // resolved direction
  } bpStrobe_t;

endpackage

// File: rtl/bp_datapath.sv
module bp_datapath #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4,
  parameter int CTR_W  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [IDX_W-1:0]         lookIdx,
  input  logic [IDX_W-1:0]         updIdx,
  input  logic [ADDR_W-IDX_W-1:0]  updTagIn,
  input  bp_pkg::bpStrobe_t        strb,
  output logic                     lookEntValid,
  output logic [ADDR_W-IDX_W-1:0]  lookEntTag,
  output logic                     lookCtrMsb,
  output logic                     updEntValid,
  output logic [ADDR_W-IDX_W-1:0]  updEntTag
);
  localparam int TAG_W     = ADDR_W - IDX_W;
  localparam int ROWS      = 1 << IDX_W;
  localparam int PHT_DEPTH = 1 << HIST_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(1);

  logic [ROWS-1:0]   entValid;
  logic [TAG_W-1:0]  entTag  [ROWS];
  logic [HIST_W-1:0] entHist [ROWS];
  logic [CTR_W-1:0]  pht     [PHT_DEPTH];

  logic [HIST_W-1:0] lookHist;
  logic [HIST_W-1:0] updHist;
  logic [CTR_W-1:0]  updCtr;
  logic [CTR_W-1:0]  ctrNext;

  always_comb begin
    lookHist     = entHist[lookIdx];
    lookEntValid = entValid[lookIdx];
    lookEntTag   = entTag[lookIdx];
    lookCtrMsb   = pht[lookHist][CTR_W-1];
    updHist      = entHist[updIdx];
    updEntValid  = entValid[updIdx];
    updEntTag    = entTag[updIdx];
    updCtr       = pht[updHist];
    if (strb.outcome) ctrNext = (updCtr == CTR_MAX) ? updCtr : updCtr + CTR_W'(1);
    else              ctrNext = (updCtr == '0)      ? updCtr : updCtr - CTR_W'(1);
  end

  // One storage row per table entry, each with its own write select.
  for (genvar r = 0; r < ROWS; r++) begin : gRow
    logic rowSel;
    assign rowSel = (updIdx == IDX_W'(r));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[r] <= 1'b0;
        entTag[r]   <= '0;
        entHist[r]  <= '0;
      end else if (rowSel && strb.alloc) begin
        entValid[r] <= 1'b1;
        entTag[r]   <= updTagIn;
        entHist[r]  <= {HIST_W{strb.outcome}};
      end else if (rowSel && strb.train) begin
        entHist[r]  <= {entHist[r][HIST_W-2:0], strb.outcome};
      end
    end
  end

  // Shared pattern table of saturating counters.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < PHT_DEPTH; p++) pht[p] <= CTR_INIT;
    end else if (strb.train) begin
      pht[updHist] <= ctrNext;
    end
  end

  AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (!rstN)
    (strb.train && strb.outcome && updCtr == CTR_MAX) |=> pht[$past(updHist)] == CTR_MAX)
    else $error("counter left upper limit"); // R5
  AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.train && !strb.outcome && updCtr == '0) |=> pht[$past(updHist)] == '0)
    else $error("counter left lower limit"); // R5
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    strb.train |=> entHist[$past(updIdx)] == {$past(updHist[HIST_W-2:0]), $past(strb.outcome)})
    else $error("history not shifted"); // R6
  AST_ALLOC_FILL: assert property (@(posedge clk) disable iff (!rstN)
    strb.alloc |=> entValid[$past(updIdx)] && entHist[$past(updIdx)] == {HIST_W{$past(strb.outcome)}})
    else $error("allocated row malformed"); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.alloc || strb.train) |=> $stable(entValid))
    else $error("valid bits changed without strobe"); // R9

endmodule

// File: rtl/bp_ctrl.sv
module bp_ctrl #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lookupValid,
  input  logic [ADDR_W-1:0]        lookupPc,
  input  logic [ADDR_W-1:0]        lookupTarget,
  input  logic                     updValid,
  input  logic                     updTaken,
  input  logic [ADDR_W-IDX_W-1:0]  lookTag,
  input  logic [ADDR_W-IDX_W-1:0]  updTag,
  input  logic                     lookEntValid,
  input  logic [ADDR_W-IDX_W-1:0]  lookEntTag,
  input  logic                     lookCtrMsb,
  input  logic                     updEntValid,
  input  logic [ADDR_W-IDX_W-1:0]  updEntTag,
  output bp_pkg::bpStrobe_t        strb,
  output logic                     predTaken,
  output logic                     predHit
);
  logic lookHit;
  logic updHit;
  logic staticTaken;

  always_comb begin
    lookHit     = lookEntValid && (lookEntTag == lookTag);
    staticTaken = lookupTarget < lookupPc;
    predHit     = lookupValid && lookHit;
    predTaken   = lookupValid && (lookHit ? lookCtrMsb : staticTaken);
    updHit      = updEntValid && (updEntTag == updTag);
    strb.alloc   = updValid && !updHit;
    strb.train   = updValid && updHit;
    strb.outcome = updTaken;
  end

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> !strb.alloc && !strb.train)
    else $error("strobe without update"); // R9

endmodule

// File: rtl/bp_hybrid_predictor.sv
module bp_hybrid_predictor #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4,
  parameter int CTR_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupPc,
  input  logic [ADDR_W-1:0] lookupTarget,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic              updTaken,
  output logic              predTaken,
  output logic              predHit
);
  localparam int TAG_W = ADDR_W - IDX_W;

  bp_pkg::bpStrobe_t strb;
  logic              lookEntValid;
  logic [TAG_W-1:0]  lookEntTag;
  logic              lookCtrMsb;
  logic              updEntValid;
  logic [TAG_W-1:0]  updEntTag;

  bp_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .lookupValid  (lookupValid),
    .lookupPc     (lookupPc),
    .lookupTarget (lookupTarget),
    .updValid     (updValid),
    .updTaken     (updTaken),
    .lookTag      (lookupPc[ADDR_W-1:IDX_W]),
    .updTag       (updPc[ADDR_W-1:IDX_W]),
    .lookEntValid (lookEntValid),
    .lookEntTag   (lookEntTag),
    .lookCtrMsb   (lookCtrMsb),
    .updEntValid  (updEntValid),
    .updEntTag    (updEntTag),
    .strb         (strb),
    .predTaken    (predTaken),
    .predHit      (predHit)
  );

  bp_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .CTR_W(CTR_W)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .lookIdx      (lookupPc[IDX_W-1:0]),
    .updIdx       (updPc[IDX_W-1:0]),
    .updTagIn     (updPc[ADDR_W-1:IDX_W]),
    .strb         (strb),
    .lookEntValid (lookEntValid),
    .lookEntTag   (lookEntTag),
    .lookCtrMsb   (lookCtrMsb),
    .updEntValid  (updEntValid),
    .updEntTag    (updEntTag)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !predTaken && !predHit)
    else $error("prediction while idle"); // R10
  AST_STATIC_RULE: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !predHit) |-> predTaken == (lookupTarget < lookupPc))
    else $error("fixed rule violated"); // R2

endmodule

// File: tb/tb_bp_hybrid_predictor.sv
module tb_bp_hybrid_predictor;
  localparam int AW = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [AW-1:0] lookupPc = '0;
  logic [AW-1:0] lookupTarget = '0;
  logic updValid = 1'b0;
  logic [AW-1:0] updPc = '0;
  logic updTaken = 1'b0;
  logic predTaken;
  logic predHit;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  // Reference model state
  bit mValid [16];
  int mTag   [16];
  int mHist  [16];
  int mPht   [16];

  always #2 clk = ~clk;

  bp_hybrid_predictor #(.ADDR_W(AW), .IDX_W(IW)) dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupPc(lookupPc),
    .lookupTarget(lookupTarget), .updValid(updValid), .updPc(updPc),
    .updTaken(updTaken), .predTaken(predTaken), .predHit(predHit)
  );

  task automatic modelReset();
    for (int i = 0; i < 16; i++) begin
      mValid[i] = 0; mTag[i] = 0; mHist[i] = 0; mPht[i] = 1;
    end
  endtask

  task automatic modelUpdate(input int pc, input bit t);
    int idx = pc & 15;
    int tg  = pc >> 4;
    if (mValid[idx] && mTag[idx] == tg) begin
      if (t && mPht[mHist[idx]] < 3) mPht[mHist[idx]]++;
      if (!t && mPht[mHist[idx]] > 0) mPht[mHist[idx]]--;
      mHist[idx] = ((mHist[idx] << 1) | int'(t)) & 15;
    end else begin
      mValid[idx] = 1; mTag[idx] = tg; mHist[idx] = t ? 15 : 0;
    end
  endtask

  // One cycle: drive at the falling edge, compare before the rising edge,
  // then advance the model past the rising edge.
  task automatic step(input bit lv, input int lpc, input int ltg,
                      input bit uv, input int upc, input bit ut, input string req);
    int idx, tg;
    bit eHit, eTaken;
    @(negedge clk);
    lookupValid = lv; lookupPc = AW'(lpc); lookupTarget = AW'(ltg);
    updValid = uv; updPc = AW'(upc); updTaken = ut;
    #1;
    idx = lpc & 15; tg = lpc >> 4;
    eHit = lv && mValid[idx] && mTag[idx] == tg;
    eTaken = lv && (eHit ? (mPht[mHist[idx]] >= 2) : (ltg < lpc));
    nChecks++;
    if (predHit !== eHit || predTaken !== eTaken) begin
      nFails++;
      $display("FAIL %s pc=%0h tgt=%0h: hit/taken got %b%b expected %b%b",
               req, lpc, ltg, predHit, predTaken, eHit, eTaken);
    end
    @(posedge clk);
    if (uv) modelUpdate(upc, ut);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int r;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 / R2: fixed rule over every address, targets below, equal, above
    for (int pc = 0; pc < 256; pc++) begin
      if (pc > 0) step(1, pc, pc - 1, 0, 0, 0, "R1_R2_backward");
      step(1, pc, pc, 0, 0, 0, "R2_equal");
      if (pc < 255) step(1, pc, pc + 1, 0, 0, 0, "R2_forward");
    end
    // R10: idle lookups give zero outputs
    step(0, 8'h10, 8'h00, 0, 0, 0, "R10");
    step(0, 8'h35, 8'h01, 1, 8'h35, 1, "R10");
    step(1, 8'h35, 8'h01, 0, 0, 0, "R7_R10_followup");

    // R8 then R7: allocate while looking up the same row
    step(1, 8'h13, 8'h05, 1, 8'h13, 1, "R8");
    step(1, 8'h13, 8'h05, 0, 0, 0, "R7_R4");
    step(1, 8'h23, 8'h05, 0, 0, 0, "R3_alias");
    // R5: saturate the counter indexed by history 1111
    for (int k = 0; k < 6; k++) step(1, 8'h13, 8'h40, 1, 8'h13, 1, "R5_R8");
    step(1, 8'h13, 8'h40, 0, 0, 0, "R5");
    // R6: one not-taken moves the history to 1110
    step(1, 8'h13, 8'h40, 1, 8'h13, 0, "R6_R8");
    step(1, 8'h13, 8'h40, 0, 0, 0, "R6");
    // R9: update port idle with live data
    for (int k = 0; k < 4; k++) step(1, 8'h13, 8'h40, 0, 8'h13, k[0], "R9");
    step(1, 8'h23, 8'h40, 0, 8'h23, 1, "R9_R3");
    // R7: alias replaces the row
    step(1, 8'h23, 8'h40, 1, 8'h23, 0, "R8_R7");
    step(1, 8'h23, 8'h40, 0, 0, 0, "R7_replace");
    step(1, 8'h13, 8'h40, 0, 0, 0, "R3_evicted");

    // Pseudo-random mix over two tags
    r = 32'h1ACE5;
    for (int n = 0; n < 4000; n++) begin
      int lpc, upc, ltg;
      bit uv, ut;
      r = (r << 1) ^ ((r[31] ^ r[21] ^ r[1] ^ r[0]) ? 1 : 0);
      r = r ^ (r >> 7) ^ (n * 32'h9E3779B9);
      upc = ((r >> 3) & 16) | (r & 15);
      lpc = r[12] ? upc : (((r >> 8) & 16) | ((r >> 13) & 15));
      ltg = (r >> 17) & 255;
      uv = r[20] | r[21];
      ut = (upc & 1) ? (r[22] | r[23]) : (r[22] & r[23]);
      step(r[24] | r[25] | r[26], lpc, ltg, uv, upc, ut, "R4_R5_R6_R8_mix");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule